// File: doc/BRIEF.md
# Data Cache Store Policy Controller

This block decides what happens to each processor store sent to a 4-way set-associative data cache with 16-byte lines of four 32-bit words. A mode input selects one of two policies. In write-back mode a hit is absorbed by the cache and the line is marked modified. A miss allocates a line, and the block fetches it from memory as a four-beat burst. In write-through mode every store goes out on an external write port, and it updates the cache only when the line is already present. The block holds the tag, valid, modified and replacement state for every set. The line data sits in an array outside the block, and the block drives that array through a word-write port.

When a write-back miss has to replace a modified line, the block first hands that victim's line address and way to a victim buffer, and only then starts the refill. If the buffer still holds an earlier victim, the miss waits until the buffer is empty. The refill starts at the missed word and wraps around the line. The store's bytes are merged into that first fetched word, so the store completes together with the refill.

Top module: `store_policy_ctrl`

## Requirements
- R1: After reset no line is valid and every output is low, so the first write-back store to any address misses and starts a refill.
- R2: A write-back store that hits is accepted in the same cycle. It writes the array word at the hit way with the store data and byte enables, marks the line modified, and drives no external write and no refill.
- R3: In write-through mode a store drives the external write port with its word-aligned address, data and byte enables. It is accepted in the cycle that ext_wr_ready is high, and on a hit the array word is written in that same cycle.
- R4: A write-through miss writes only to the external port. It writes no array word and allocates no line, so a later write-back store to the same address misses.
- R5: A write-back miss allocates the lowest-numbered invalid way of the set, or the least recently used way when all four are valid. After the refill the line is valid and modified, and a later store to it hits.
- R6: A hit in either mode, and a completed allocation, make that way the most recently used of its set. A write-through miss leaves the ordering unchanged.
- R7: When the victim of a write-back miss is valid and modified, vbuf_push is high for one cycle, with vbuf_addr set to the victim's line address (offset bits zero) and vbuf_way set to its way. The first refill beat is requested in the next cycle.
- R8: While vbuf_busy is high, a write-back miss whose victim is modified does not push, does not refill and is not accepted. It proceeds once vbuf_busy is low.
- R9: A refill requests four words. It starts at the missed word (address bits [3:2]) and increments modulo four. Each request holds fill_addr steady until fill_ack.
- R10: Each acknowledged beat writes fill_rdata, with all byte enables, to the array word at the allocated way. On the first beat the store's enabled bytes replace the fetched bytes.
- R11: st_ready stays low from a write-back miss until the refill ends, and it is high in the cycle after the last acknowledged beat.
- R12: The address splits into byte [1:0], word [3:2], set [SET_W+3:4] and tag above it. fill_addr and ext_wr_addr have bits [1:0] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back policy, 0 = write-through policy |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Store byte address |
| st_wdata | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store accepted this cycle |
| arr_we | output | 1 | Line array word write |
| arr_set | output | SET_W | Set of the array write |
| arr_way | output | 2 | Way of the array write |
| arr_word | output | 2 | Word within the line |
| arr_be | output | 4 | Byte enables of the array write |
| arr_wdata | output | 32 | Array write data |
| ext_wr_valid | output | 1 | External write request |
| ext_wr_addr | output | ADDR_W | External write word address |
| ext_wr_data | output | 32 | External write data |
| ext_wr_be | output | 4 | External write byte enables |
| ext_wr_ready | input | 1 | External write accepted |
| fill_valid | output | 1 | Refill word request |
| fill_addr | output | ADDR_W | Address of the requested word |
| fill_ack | input | 1 | Requested word is on fill_rdata |
| fill_rdata | input | 32 | Refill word data |
| vbuf_push | output | 1 | Hand the victim line to the victim buffer |
| vbuf_addr | output | ADDR_W | Victim line address |
| vbuf_way | output | 2 | Victim way, for copying its data |
| vbuf_busy | input | 1 | Victim buffer still holds a line |

## Verification
The bench targets refills that start at words 0, 1 and 3. A wrong wrap order or base would put fetched words into the wrong array slots. A missing merge on the first beat would silently drop the store. The bench fills all four ways of a set and then hits the oldest way to re-order them, so a design that chose the victim by way number or by fill order would evict a line that had just been used. It also issues two dirty evictions back to back while the victim buffer is still full. A design that ignored the buffer state would push over a line that had not yet been written back. Finally, a write-through miss is followed by a write-back store to the same address, which exposes any design that allocated on write-through misses.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int WORD_W     = 32;
    localparam int BE_W       = WORD_W / 8;
    localparam int LINE_BEATS = 4;
    localparam int BEAT_W     = $clog2(LINE_BEATS);
    localparam int OFF_W      = BEAT_W + $clog2(BE_W);
    localparam int WAYS       = 4;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int AGE_W      = WAYS * (WAYS - 1) / 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DONE
    } ctl_state_e;

    // Pair bit p for ways (i, j), i < j, is 1 when way i is older than way j.
    function automatic logic [AGE_W-1:0] age_touch(input logic [AGE_W-1:0] age,
                                                   input logic [WAY_W-1:0] way);
        logic [AGE_W-1:0] res;
        int p;
        res = age;
        p   = 0;
        for (int i = 0; i < WAYS - 1; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (i == int'(way)) res[p] = 1'b0;
                else if (j == int'(way)) res[p] = 1'b1;
                p++;
            end
        end
        return res;
    endfunction

    function automatic logic [WAY_W-1:0] age_oldest(input logic [AGE_W-1:0] age);
        logic [WAY_W-1:0] res;
        logic             ok;
        int               p;
        res = '0;
        for (int w = 0; w < WAYS; w++) begin
            ok = 1'b1;
            p  = 0;
            for (int i = 0; i < WAYS - 1; i++) begin
                for (int j = i + 1; j < WAYS; j++) begin
                    if (i == w && !age[p]) ok = 1'b0;
                    if (j == w && age[p]) ok = 1'b0;
                    p++;
                end
            end
            if (ok) res = WAY_W'(w);
        end
        return res;
    endfunction

    function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] base,
                                                      input logic [WORD_W-1:0] upd,
                                                      input logic [BE_W-1:0] be);
        logic [WORD_W-1:0] res;
        for (int b = 0; b < BE_W; b++)
            res[b*8 +: 8] = be[b] ? upd[b*8 +: 8] : base[b*8 +: 8];
        return res;
    endfunction

endpackage

// File: rtl/spc_tag_store.sv
module spc_tag_store
    import spc_pkg::*;
#(
    parameter  int SETS  = 4,
    parameter  int TAG_W = 10,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]            rd_vld,
    output logic [WAYS-1:0]            rd_drt,
    output logic [AGE_W-1:0]           rd_age,
    input  logic                       upd_en,
    input  logic                       upd_alloc,
    input  logic                       upd_dirty,
    input  logic [SET_W-1:0]           upd_set,
    input  logic [WAY_W-1:0]           upd_way,
    input  logic [TAG_W-1:0]           upd_tag
);

    typedef struct packed {
        logic [WAYS-1:0][TAG_W-1:0] tag;
        logic [WAYS-1:0]            vld;
        logic [WAYS-1:0]            drt;
        logic [AGE_W-1:0]           age;
    } set_t;

    set_t sets_d [SETS];
    set_t sets_q [SETS];

    always_comb begin
        sets_d = sets_q;
        if (upd_en) begin
            sets_d[upd_set].age = age_touch(sets_q[upd_set].age, upd_way);
            if (upd_alloc) begin
                sets_d[upd_set].tag[upd_way] = upd_tag;
                sets_d[upd_set].vld[upd_way] = 1'b1;
            end
            if (upd_dirty) sets_d[upd_set].drt[upd_way] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sets_q <= '{default: '0};
        else        sets_q <= sets_d;
    end

    assign rd_tag = sets_q[rd_set].tag;
    assign rd_vld = sets_q[rd_set].vld;
    assign rd_drt = sets_q[rd_set].drt;
    assign rd_age = sets_q[rd_set].age;

endmodule

// File: rtl/spc_fill_seq.sv
module spc_fill_seq #(
    parameter  int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] cur_idx,
    output logic             first,
    output logic             last
);

    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.base = start_idx;
            seq_d.cnt  = '0;
        end else if (advance) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign cur_idx = seq_q.base + seq_q.cnt;
    assign first   = (seq_q.cnt == '0);
    assign last    = (seq_q.cnt == IDX_W'(BEATS - 1));

endmodule

// File: rtl/store_policy_ctrl.sv
module store_policy_ctrl
    import spc_pkg::*;
#(
    parameter  int ADDR_W = 16,
    parameter  int SETS   = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_wdata,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_ready,
    output logic              arr_we,
    output logic [SET_W-1:0]  arr_set,
    output logic [WAY_W-1:0]  arr_way,
    output logic [BEAT_W-1:0] arr_word,
    output logic [BE_W-1:0]   arr_be,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              ext_wr_valid,
    output logic [ADDR_W-1:0] ext_wr_addr,
    output logic [WORD_W-1:0] ext_wr_data,
    output logic [BE_W-1:0]   ext_wr_be,
    input  logic              ext_wr_ready,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack,
    input  logic [WORD_W-1:0] fill_rdata,
    output logic              vbuf_push,
    output logic [ADDR_W-1:0] vbuf_addr,
    output logic [WAY_W-1:0]  vbuf_way,
    input  logic              vbuf_busy
);

    typedef struct packed {
        ctl_state_e        st;
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [WAY_W-1:0]  way;
        logic [WORD_W-1:0] data;
        logic [BE_W-1:0]   be;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SET_W-1:0]           in_set;
    logic [TAG_W-1:0]           in_tag;
    logic [BEAT_W-1:0]          in_word;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_vld, rd_drt;
    logic [AGE_W-1:0]           rd_age;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way, vic_way;
    logic                       vic_dirty;
    logic                       upd_en, upd_alloc, upd_dirty;
    logic [SET_W-1:0]           upd_set;
    logic [WAY_W-1:0]           upd_way;
    logic [TAG_W-1:0]           upd_tag;
    logic                       seq_start, seq_adv, seq_first, seq_last;
    logic [BEAT_W-1:0]          seq_idx;
    logic                       unused_byte_bits;

    assign in_set           = st_addr[OFF_W +: SET_W];
    assign in_tag           = st_addr[ADDR_W-1 -: TAG_W];
    assign in_word          = st_addr[OFF_W-1 -: BEAT_W];
    assign unused_byte_bits = ^st_addr[OFF_W-BEAT_W-1:0];

    spc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (in_set),
        .rd_tag   (rd_tag),
        .rd_vld   (rd_vld),
        .rd_drt   (rd_drt),
        .rd_age   (rd_age),
        .upd_en   (upd_en),
        .upd_alloc(upd_alloc),
        .upd_dirty(upd_dirty),
        .upd_set  (upd_set),
        .upd_way  (upd_way),
        .upd_tag  (upd_tag)
    );

    spc_fill_seq #(.BEATS(LINE_BEATS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .start_idx(in_word),
        .advance  (seq_adv),
        .cur_idx  (seq_idx),
        .first    (seq_first),
        .last     (seq_last)
    );

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_vld[w] && rd_tag[w] == in_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        vic_way = age_oldest(rd_age);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!rd_vld[w]) vic_way = WAY_W'(w);
        vic_dirty = rd_vld[vic_way] && rd_drt[vic_way];
    end

    always_comb begin
        ctl_d        = ctl_q;
        st_ready     = 1'b0;
        arr_we       = 1'b0;
        arr_set      = in_set;
        arr_way      = hit_way;
        arr_word     = in_word;
        arr_be       = st_be;
        arr_wdata    = st_wdata;
        ext_wr_valid = 1'b0;
        ext_wr_addr  = {st_addr[ADDR_W-1:OFF_W-BEAT_W], {(OFF_W-BEAT_W){1'b0}}};
        ext_wr_data  = st_wdata;
        ext_wr_be    = st_be;
        fill_valid   = 1'b0;
        fill_addr    = {ctl_q.tag, ctl_q.set, seq_idx, {(OFF_W-BEAT_W){1'b0}}};
        vbuf_push    = 1'b0;
        vbuf_addr    = {rd_tag[vic_way], in_set, {OFF_W{1'b0}}};
        vbuf_way     = vic_way;
        upd_en       = 1'b0;
        upd_alloc    = 1'b0;
        upd_dirty    = 1'b0;
        upd_set      = in_set;
        upd_way      = hit_way;
        upd_tag      = ctl_q.tag;
        seq_start    = 1'b0;
        seq_adv      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (st_valid && wb_mode) begin
                    if (hit) begin
                        st_ready  = 1'b1;
                        arr_we    = 1'b1;
                        upd_en    = 1'b1;
                        upd_dirty = 1'b1;
                    end else if (!(vic_dirty && vbuf_busy)) begin
                        vbuf_push  = vic_dirty;
                        seq_start  = 1'b1;
                        ctl_d.st   = ST_FILL;
                        ctl_d.tag  = in_tag;
                        ctl_d.set  = in_set;
                        ctl_d.way  = vic_way;
                        ctl_d.data = st_wdata;
                        ctl_d.be   = st_be;
                    end
                end else if (st_valid) begin
                    ext_wr_valid = 1'b1;
                    if (ext_wr_ready) begin
                        st_ready = 1'b1;
                        arr_we   = hit;
                        upd_en   = hit;
                    end
                end
            end
            ST_FILL: begin
                fill_valid = 1'b1;
                arr_set    = ctl_q.set;
                arr_way    = ctl_q.way;
                arr_word   = seq_idx;
                arr_be     = '1;
                arr_wdata  = seq_first ? merge_bytes(fill_rdata, ctl_q.data, ctl_q.be)
                                       : fill_rdata;
                if (fill_ack) begin
                    arr_we  = 1'b1;
                    seq_adv = 1'b1;
                    if (seq_last) begin
                        upd_en    = 1'b1;
                        upd_alloc = 1'b1;
                        upd_dirty = 1'b1;
                        upd_set   = ctl_q.set;
                        upd_way   = ctl_q.way;
                        ctl_d.st  = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                st_ready = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/store_policy_ctrl_chk.sv
module store_policy_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_mode,
    input logic              st_ready,
    input logic              ext_wr_valid,
    input logic              ext_wr_ready,
    input logic              fill_valid,
    input logic              fill_ack,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              arr_we,
    input logic              vbuf_push,
    input logic              vbuf_busy
);

    // R7
    push_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbuf_push |=> fill_valid);

    // R8
    push_idle_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbuf_push |-> !vbuf_busy);

    // R11
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !st_ready);

    // R11
    fill_end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_valid) |-> st_ready);

    // R9
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !fill_ack |=> fill_valid && $stable(fill_addr));

    // R10
    beat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && fill_ack |-> arr_we);

    // R3
    ext_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_valid && !ext_wr_ready |-> !st_ready);

    // R2
    wb_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_mode |-> !ext_wr_valid);

endmodule

bind store_policy_ctrl store_policy_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_mode     (wb_mode),
    .st_ready    (st_ready),
    .ext_wr_valid(ext_wr_valid),
    .ext_wr_ready(ext_wr_ready),
    .fill_valid  (fill_valid),
    .fill_ack    (fill_ack),
    .fill_addr   (fill_addr),
    .arr_we      (arr_we),
    .vbuf_push   (vbuf_push),
    .vbuf_busy   (vbuf_busy)
);

// File: tb/store_policy_ctrl_bench.sv
`timescale 1ns/1ps
module store_policy_ctrl_bench;

    logic        clk = 1'b0, rst_n = 1'b0, wb_mode = 1'b1, st_valid = 1'b0;
    logic [15:0] st_addr = '0;
    logic [31:0] st_wdata = '0;
    logic [3:0]  st_be = '0;
    logic        ext_wr_ready = 1'b0, fill_ack = 1'b0, vbuf_busy = 1'b0;
    logic [31:0] fill_rdata;
    logic        st_ready, arr_we, ext_wr_valid, fill_valid, vbuf_push;
    logic [1:0]  arr_set, arr_way, arr_word, vbuf_way;
    logic [3:0]  arr_be, ext_wr_be;
    logic [31:0] arr_wdata, ext_wr_data;
    logic [15:0] ext_wr_addr, fill_addr, vbuf_addr;

    always #4 clk = ~clk;

    assign fill_rdata = {fill_addr, fill_addr ^ 16'hC3A5};

    store_policy_ctrl u_store_policy_ctrl (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .st_valid(st_valid), .st_addr(st_addr), .st_wdata(st_wdata), .st_be(st_be),
        .st_ready(st_ready),
        .arr_we(arr_we), .arr_set(arr_set), .arr_way(arr_way), .arr_word(arr_word),
        .arr_be(arr_be), .arr_wdata(arr_wdata),
        .ext_wr_valid(ext_wr_valid), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
        .ext_wr_be(ext_wr_be), .ext_wr_ready(ext_wr_ready),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_ack(fill_ack),
        .fill_rdata(fill_rdata),
        .vbuf_push(vbuf_push), .vbuf_addr(vbuf_addr), .vbuf_way(vbuf_way),
        .vbuf_busy(vbuf_busy)
    );

    int    checks = 0, errors = 0, cyc = 0, busy_len = 0, busy_cnt = 0;
    string cur_req = "R1";
    bit    rdy_seen = 0, saw_fill = 0, done = 0;
    logic [15:0] fq[$];
    int    push_cyc[$];

    // reference state: tags, valid, modified, last-use stamps per set/way
    int mt[4][4], mts[4][4];
    bit mv[4][4], md[4][4];
    int mstate = 0, mbeat = 0, stamp = 0;
    int lt, ls, lw, lv;
    logic [31:0] ld;
    logic [3:0]  lb;
    int p_kind, p_set, p_way, p_state, p_beat;
    bit p_dirty, p_latch;
    int q_t, q_s, q_w, q_v;
    logic [31:0] q_d;
    logic [3:0]  q_b;
    bit e_rdy;
    logic [63:0] e_arr, e_ext, e_fill, e_push;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: act=%h exp=%h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int t, input int s, input int w);
        return 16'((t << 6) | (s << 4) | (w << 2));
    endfunction

    // stimulus from memory, external port and victim buffer
    always @(negedge clk) begin
        cyc++;
        fill_ack     = (cyc % 3) != 0;
        ext_wr_ready = (cyc % 4) != 1;
        vbuf_busy    = busy_cnt > 0;
    end

    // expected outputs for this cycle, compared away from the edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            int s, t, w, hw, v, wd;
            bit hit;
            logic [31:0] dat;
            e_rdy = 0; e_arr = '0; e_ext = '0; e_fill = '0; e_push = '0;
            p_kind = 0; p_state = mstate; p_beat = mbeat; p_latch = 0; p_dirty = 0;
            s = int'(st_addr[5:4]); t = int'(st_addr[15:6]); wd = int'(st_addr[3:2]);
            if (mstate == 0 && st_valid) begin
                hit = 0; hw = 0;
                for (int k = 0; k < 4; k++)
                    if (mv[s][k] && mt[s][k] == t) begin hit = 1; hw = k; end
                if (wb_mode) begin
                    if (hit) begin
                        e_rdy = 1;
                        e_arr = {1'b1, 2'(s), 2'(hw), 2'(wd), st_be, st_wdata};
                        p_kind = 1; p_dirty = 1; p_set = s; p_way = hw;
                    end else begin
                        v = -1;
                        for (int k = 0; k < 4; k++) if (!mv[s][k] && v < 0) v = k;
                        if (v < 0) begin
                            v = 0;
                            for (int k = 1; k < 4; k++) if (mts[s][k] < mts[s][v]) v = k;
                        end
                        if (!(mv[s][v] && md[s][v] && vbuf_busy)) begin
                            if (mv[s][v] && md[s][v])
                                e_push = {1'b1, mk(mt[s][v], s, 0), 2'(v)};
                            p_state = 1; p_beat = 0; p_latch = 1;
                            q_t = t; q_s = s; q_w = wd; q_v = v; q_d = st_wdata; q_b = st_be;
                        end
                    end
                end else begin
                    e_ext = {1'b1, mk(t, s, wd), st_wdata, st_be};
                    if (ext_wr_ready) begin
                        e_rdy = 1;
                        if (hit) begin
                            e_arr = {1'b1, 2'(s), 2'(hw), 2'(wd), st_be, st_wdata};
                            p_kind = 1; p_set = s; p_way = hw;
                        end
                    end
                end
            end else if (mstate == 1) begin
                w = (lw + mbeat) % 4;
                e_fill = {1'b1, mk(lt, ls, w)};
                if (fill_ack) begin
                    dat = {mk(lt, ls, w), mk(lt, ls, w) ^ 16'hC3A5};
                    if (mbeat == 0)
                        for (int b = 0; b < 4; b++) if (lb[b]) dat[b*8 +: 8] = ld[b*8 +: 8];
                    e_arr = {1'b1, 2'(ls), 2'(lv), 2'(w), 4'hF, dat};
                    p_beat = mbeat + 1;
                    if (mbeat == 3) begin p_kind = 2; p_state = 2; end
                end
            end else if (mstate == 2) begin
                e_rdy = 1; p_state = 0;
            end
            check({cur_req, " st_ready"}, 64'(st_ready), 64'(e_rdy));
            check({cur_req, " array write"},
                  arr_we ? 64'({1'b1, arr_set, arr_way, arr_word, arr_be, arr_wdata}) : '0, e_arr);
            check({cur_req, " external write"},
                  ext_wr_valid ? 64'({1'b1, ext_wr_addr, ext_wr_data, ext_wr_be}) : '0, e_ext);
            check({cur_req, " refill request"},
                  fill_valid ? 64'({1'b1, fill_addr}) : '0, e_fill);
            check({cur_req, " victim push"},
                  vbuf_push ? 64'({1'b1, vbuf_addr, vbuf_way}) : '0, e_push);
            rdy_seen = st_ready;
            if (fill_valid) saw_fill = 1;
            if (fill_valid && fill_ack) fq.push_back(fill_addr);
            if (vbuf_push) push_cyc.push_back(cyc);
        end
    end

    always @(posedge clk) begin
        if (rst_n && !done) begin
            if (e_push[18]) busy_cnt = busy_len;
            else if (busy_cnt > 0) busy_cnt--;
            if (p_kind != 0) begin
                stamp++;
                if (p_kind == 2) begin
                    mt[ls][lv] = lt; mv[ls][lv] = 1; md[ls][lv] = 1;
                    mts[ls][lv] = stamp;
                end else begin
                    if (p_dirty) md[p_set][p_way] = 1;
                    mts[p_set][p_way] = stamp;
                end
            end
            if (p_latch) begin
                lt = q_t; ls = q_s; lw = q_w; lv = q_v; ld = q_d; lb = q_b;
            end
            mstate = p_state; mbeat = p_beat;
            p_kind = 0; p_latch = 0; e_push = '0;
        end
    end

    task automatic store(input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] be, input bit wb);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_wdata = d; st_be = be; wb_mode = wb;
        forever begin
            @(posedge clk);
            if (rdy_seen) break;
        end
        @(negedge clk);
        st_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog: act=hung exp=finished");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin mt[i][j] = 0; mts[i][j] = 0; mv[i][j] = 0; md[i][j] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check("R1 reset outputs",
              64'({st_ready, arr_we, ext_wr_valid, fill_valid, vbuf_push}), 64'(0));
        rst_n = 1;

        // R1/R10/R9: first store misses, refill wraps from word 1 with merge
        cur_req = "R10"; fq.delete(); saw_fill = 0;
        store(mk(1, 0, 1), 32'h1122_3344, 4'b0110, 1);
        check("R1 first store refilled", 64'(saw_fill), 64'(1));
        check("R9 wrap order from word 1",
              fq.size() == 4 ? {fq[0], fq[1], fq[2], fq[3]} : '0,
              {mk(1, 0, 1), mk(1, 0, 2), mk(1, 0, 3), mk(1, 0, 0)});

        cur_req = "R2";
        store(mk(1, 0, 3), 32'hDEAD_BEEF, 4'b1001, 1);

        cur_req = "R5";
        store(mk(2, 0, 0), 32'hA0A0_0002, 4'hF, 1);
        store(mk(3, 0, 2), 32'hA0A0_0003, 4'hF, 1);
        store(mk(4, 0, 3), 32'hA0A0_0004, 4'hF, 1);
        cur_req = "R6";
        store(mk(1, 0, 0), 32'h0000_0101, 4'b0001, 1);

        cur_req = "R7"; busy_len = 30; push_cyc.delete();
        store(mk(5, 0, 2), 32'h5555_0005, 4'b1100, 1);
        cur_req = "R8";
        store(mk(6, 0, 1), 32'h6666_0006, 4'hF, 1);
        check("R7 dirty victims pushed", 64'(push_cyc.size()), 64'(2));
        if (push_cyc.size() == 2)
            check("R8 push held while buffer busy",
                  64'(push_cyc[1] - push_cyc[0] >= 30), 64'(1));

        cur_req = "R3"; busy_len = 4;
        store(mk(1, 0, 2), 32'h3333_0001, 4'b0011, 0);
        store(mk(6, 0, 0), 32'h3333_0006, 4'hF, 0);

        cur_req = "R4";
        store(mk(9, 1, 1), 32'h4444_0009, 4'b1000, 0);
        saw_fill = 0;
        store(mk(9, 1, 1), 32'h4444_1009, 4'b0001, 1);
        check("R4 write-through miss did not allocate", 64'(saw_fill), 64'(1));

        cur_req = "R11"; fq.delete();
        store(mk(7, 2, 0), 32'h7777_0000, 4'hF, 1);
        store(mk(8, 2, 3), 32'h8888_0003, 4'b0100, 1);
        check("R9 wrap order from words 0 and 3",
              fq.size() == 8 ? {fq[0], fq[3], fq[4], fq[7]} : '0,
              {mk(7, 2, 0), mk(7, 2, 3), mk(8, 2, 3), mk(8, 2, 2)});

        cur_req = "R12";
        store(mk(9, 3, 2) | 16'h0003, 32'hCAFE_0012, 4'b1010, 0);
        store(mk(9, 3, 2) | 16'h0001, 32'hCAFE_0112, 4'b0101, 1);

        cur_req = "R6"; lf = 16'hACE1; busy_len = 5;
        for (int n = 0; n < 80; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            store(mk(1 + int'(lf[2:0]) % 6, int'(lf[4:3]), int'(lf[6:5])),
                  {lf, ~lf}, (lf[10:7] == 0) ? 4'h1 : lf[10:7], lf[11] | lf[12]);
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule